// File: doc/BRIEF.md
# Color-Banked Host Register Port

This block is the host-side register file of a three-channel imaging front end. An 8-bit parallel host bus, with three address lines and active-low chip-select, read and write strobes, reaches eight register slots. Three of the slots are banked: the per-color gain, the per-color odd-pixel offset and the per-color even-pixel offset each exist once for red, once for green and once for blue. A 2-bit color pointer in the top two bits of the configuration register selects which copy a banked access touches. With this pointer the address space stays at eight slots, while nine banked values and four global values are held.

Register readback uses the same output pins as the converted sample stream. An active-low output enable turns the pins on. While a host read is active, the pins carry the register value, zero-extended. At all other times they carry the sample word. Every register resets to zero, which leaves both digital correction stages bypassed. The block is synchronous to a system clock that samples the host strobes.

Top module: `color_reg_port`

## Requirements
- R1: While reset is asserted and after it is released, every register output is zero and every register reads back zero.
- R2: A write commits on the first clock edge at which the write strobe is seen high after being seen low, with chip-select low at both samples. The address and data latched while the strobe was low are used. A strobe with chip-select high changes nothing, and nothing changes while the strobe stays low.
- R3: Address 0 holds the configuration register, address 1 a second configuration register, address 5 the input offset and address 7 the Bayer-mode register. Each is written and read directly.
- R4: Address 2 (gain), address 3 (odd offset) and address 4 (even offset) are banked. A write goes only to the copy chosen by configuration bits [7:6]: 00 red, 01 green, 10 blue. On the flat outputs, red is bits [7:0], green bits [15:8] and blue bits [23:16].
- R5: With the color pointer at 11, banked writes are dropped and banked reads return zero.
- R6: A banked read returns the copy selected by the current color pointer.
- R7: Address 6 is reserved. Writes to it change no register, and reads of it return zero.
- R8: When oe_n is high, dout is zero and dout_oe is low. When oe_n is low and cs_n and rd_n are both low, dout is the addressed register in bits [7:0] with bits [11:8] zero. When oe_n is low and no read is active, dout is sample_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable for shared pins, active low |
| addr | input | 3 | Register address |
| host_din | input | 8 | Host write data |
| sample_in | input | 12 | Sample word from the conversion path |
| dout | output | 12 | Shared output: sample or register readback |
| dout_oe | output | 1 | High when the shared pins are driven |
| cfg_o | output | 8 | Configuration register |
| cfg2_o | output | 8 | Second configuration register |
| gain_rgb | output | 24 | Gain copies {blue, green, red} |
| odd_off_rgb | output | 24 | Odd offset copies {blue, green, red} |
| even_off_rgb | output | 24 | Even offset copies {blue, green, red} |
| in_off_o | output | 8 | Input offset register |
| bayer_o | output | 8 | Bayer-mode register |

## Verification
The hardest case is a banked access whose result depends on a pointer value set by an earlier write. To reach it, the stimulus table moves the pointer through red, green and blue before each group of banked writes. It then returns the pointer to earlier colors and reads back, so a copy left stale or written to the wrong lane shows up. A directed sequence sets the pointer to 11 before a gain write. A second holds the write strobe low over several clock edges, so an early commit can be seen before the strobe rises.

// File: rtl/color_reg_port_pkg.sv
package color_reg_port_pkg;

    localparam int unsigned HOST_ADDR_W  = 3;
    localparam int unsigned COLOR_PTR_W  = 2;

    typedef enum logic [HOST_ADDR_W-1:0] {
        SLOT_CFG      = 3'd0,
        SLOT_CFG2     = 3'd1,
        SLOT_GAIN     = 3'd2,
        SLOT_ODD_OFF  = 3'd3,
        SLOT_EVEN_OFF = 3'd4,
        SLOT_IN_OFF   = 3'd5,
        SLOT_RSVD     = 3'd6,
        SLOT_BAYER    = 3'd7
    } slot_e;

endpackage

// File: rtl/host_strobe.sv
module host_strobe
    import color_reg_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   wr_n,
    input  logic [HOST_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]      din,
    output logic                   wr_commit,
    output logic [HOST_ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]      wr_data
);

    typedef struct packed {
        logic                   wr_low;
        logic [HOST_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]      data;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.wr_low = !wr_n && !cs_n;
        if (!wr_n && !cs_n) begin
            st_d.addr = addr;
            st_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_commit = st_q.wr_low && wr_n && !cs_n;
    assign wr_addr   = st_q.addr;
    assign wr_data   = st_q.data;

endmodule

// File: rtl/color_bank.sv
module color_bank
    import color_reg_port_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_COLORS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [COLOR_PTR_W-1:0]       ptr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_COLORS*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]            rdata
);

    logic [NUM_COLORS-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [NUM_COLORS-1:0]             lane_hit;

    for (genvar c = 0; c < NUM_COLORS; c++) begin : g_lane
        assign lane_hit[c] = (ptr == COLOR_PTR_W'(c));
        assign bank_flat[c*DATA_W +: DATA_W] = bank_q[c];
    end

    always_comb begin
        bank_d = bank_q;
        rdata  = '0;
        for (int c = 0; c < NUM_COLORS; c++) begin
            if (wr_en && lane_hit[c]) begin
                bank_d[c] = wdata;
            end
            if (lane_hit[c]) begin
                rdata = bank_q[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/readback_mux.sv
module readback_mux
    import color_reg_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [HOST_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]      cfg,
    input  logic [DATA_W-1:0]      cfg2,
    input  logic [DATA_W-1:0]      in_off,
    input  logic [DATA_W-1:0]      bayer,
    input  logic [DATA_W-1:0]      gain_sel,
    input  logic [DATA_W-1:0]      odd_sel,
    input  logic [DATA_W-1:0]      even_sel,
    output logic [DATA_W-1:0]      rdata
);

    always_comb begin
        case (slot_e'(addr))
            SLOT_CFG:      rdata = cfg;
            SLOT_CFG2:     rdata = cfg2;
            SLOT_GAIN:     rdata = gain_sel;
            SLOT_ODD_OFF:  rdata = odd_sel;
            SLOT_EVEN_OFF: rdata = even_sel;
            SLOT_IN_OFF:   rdata = in_off;
            SLOT_BAYER:    rdata = bayer;
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/color_reg_port.sv
module color_reg_port
    import color_reg_port_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned NUM_COLORS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         rd_n,
    input  logic                         wr_n,
    input  logic                         oe_n,
    input  logic [HOST_ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]            host_din,
    input  logic [SAMPLE_W-1:0]          sample_in,
    output logic [SAMPLE_W-1:0]          dout,
    output logic                         dout_oe,
    output logic [DATA_W-1:0]            cfg_o,
    output logic [DATA_W-1:0]            cfg2_o,
    output logic [NUM_COLORS*DATA_W-1:0] gain_rgb,
    output logic [NUM_COLORS*DATA_W-1:0] odd_off_rgb,
    output logic [NUM_COLORS*DATA_W-1:0] even_off_rgb,
    output logic [DATA_W-1:0]            in_off_o,
    output logic [DATA_W-1:0]            bayer_o
);

    localparam int unsigned PAD_W   = SAMPLE_W - DATA_W;
    localparam int unsigned PTR_MSB = DATA_W - 1;
    localparam int unsigned N_BANKS = 3;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] cfg2;
        logic [DATA_W-1:0] in_off;
        logic [DATA_W-1:0] bayer;
    } glob_t;

    glob_t glob_d, glob_q;

    logic                   wr_commit;
    logic [HOST_ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0]      wr_data;
    logic [COLOR_PTR_W-1:0] color_ptr;
    logic [DATA_W-1:0]      rd_data;
    logic                   rd_active;

    logic [N_BANKS-1:0]                        bank_we;
    logic [N_BANKS-1:0][DATA_W-1:0]            bank_rd;
    logic [N_BANKS-1:0][NUM_COLORS*DATA_W-1:0] bank_out;

    host_strobe #(
        .DATA_W (DATA_W)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (host_din),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign color_ptr = glob_q.cfg[PTR_MSB -: COLOR_PTR_W];

    always_comb begin
        bank_we    = '0;
        bank_we[0] = wr_commit && (slot_e'(wr_addr) == SLOT_GAIN);
        bank_we[1] = wr_commit && (slot_e'(wr_addr) == SLOT_ODD_OFF);
        bank_we[2] = wr_commit && (slot_e'(wr_addr) == SLOT_EVEN_OFF);
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        color_bank #(
            .DATA_W     (DATA_W),
            .NUM_COLORS (NUM_COLORS)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bank_we[b]),
            .ptr       (color_ptr),
            .wdata     (wr_data),
            .bank_flat (bank_out[b]),
            .rdata     (bank_rd[b])
        );
    end

    always_comb begin
        glob_d = glob_q;
        if (wr_commit) begin
            case (slot_e'(wr_addr))
                SLOT_CFG:    glob_d.cfg    = wr_data;
                SLOT_CFG2:   glob_d.cfg2   = wr_data;
                SLOT_IN_OFF: glob_d.in_off = wr_data;
                SLOT_BAYER:  glob_d.bayer  = wr_data;
                default:     glob_d        = glob_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q <= '0;
        end else begin
            glob_q <= glob_d;
        end
    end

    readback_mux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .addr     (addr),
        .cfg      (glob_q.cfg),
        .cfg2     (glob_q.cfg2),
        .in_off   (glob_q.in_off),
        .bayer    (glob_q.bayer),
        .gain_sel (bank_rd[0]),
        .odd_sel  (bank_rd[1]),
        .even_sel (bank_rd[2]),
        .rdata    (rd_data)
    );

    assign rd_active = !cs_n && !rd_n;

    always_comb begin
        dout_oe = !oe_n;
        if (oe_n) begin
            dout = '0;
        end else if (rd_active) begin
            dout = {{PAD_W{1'b0}}, rd_data};
        end else begin
            dout = sample_in;
        end
    end

    assign cfg_o        = glob_q.cfg;
    assign cfg2_o       = glob_q.cfg2;
    assign in_off_o     = glob_q.in_off;
    assign bayer_o      = glob_q.bayer;
    assign gain_rgb     = bank_out[0];
    assign odd_off_rgb  = bank_out[1];
    assign even_off_rgb = bank_out[2];

endmodule

// File: rtl/color_reg_port_chk.sv
module color_reg_port_chk #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned NUM_COLORS = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         rd_n,
    input logic                         oe_n,
    input logic [2:0]                   addr,
    input logic [SAMPLE_W-1:0]          dout,
    input logic                         dout_oe,
    input logic [DATA_W-1:0]            cfg_o,
    input logic [NUM_COLORS*DATA_W-1:0] gain_rgb,
    input logic [NUM_COLORS*DATA_W-1:0] odd_off_rgb,
    input logic [NUM_COLORS*DATA_W-1:0] even_off_rgb
);

    logic [NUM_COLORS*DATA_W-1:0] gain_prev;
    logic [NUM_COLORS-1:0]        lane_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_prev <= '0;
        end else begin
            gain_prev <= gain_rgb;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_COLORS; c++) begin
            lane_chg[c] = gain_rgb[c*DATA_W +: DATA_W] != gain_prev[c*DATA_W +: DATA_W];
        end
    end

    AST_CS_HIGH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(cfg_o) && $stable(gain_rgb) && $stable(odd_off_rgb) && $stable(even_off_rgb))); // R2

    AST_ONE_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_chg)); // R4

    AST_NO_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[DATA_W-1 -: 2] == 2'b11) |=> ($stable(gain_rgb) && $stable(odd_off_rgb) && $stable(even_off_rgb))); // R5

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !cs_n && !rd_n && addr == 3'd6) |-> (dout == '0)); // R7

    AST_PINS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dout == '0 && !dout_oe)); // R8

endmodule

bind color_reg_port color_reg_port_chk #(
    .DATA_W     (DATA_W),
    .SAMPLE_W   (SAMPLE_W),
    .NUM_COLORS (NUM_COLORS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .oe_n         (oe_n),
    .addr         (addr),
    .dout         (dout),
    .dout_oe      (dout_oe),
    .cfg_o        (cfg_o),
    .gain_rgb     (gain_rgb),
    .odd_off_rgb  (odd_off_rgb),
    .even_off_rgb (even_off_rgb)
);

// File: tb/color_reg_port_bench.sv
`timescale 1ns/1ps
module color_reg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  host_din = '0;
    logic [11:0] sample_in = '0;
    logic [11:0] dout;
    logic        dout_oe;
    logic [7:0]  cfg_o, cfg2_o, in_off_o, bayer_o;
    logic [23:0] gain_rgb, odd_off_rgb, even_off_rgb;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rd_val;

    always #2 clk = ~clk;

    color_reg_port u_color_reg_port (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .oe_n (oe_n), .addr (addr), .host_din (host_din), .sample_in (sample_in),
        .dout (dout), .dout_oe (dout_oe), .cfg_o (cfg_o), .cfg2_o (cfg2_o),
        .gain_rgb (gain_rgb), .odd_off_rgb (odd_off_rgb), .even_off_rgb (even_off_rgb),
        .in_off_o (in_off_o), .bayer_o (bayer_o)
    );

    // entry: [19] read, [18:16] address, [15:8] write data, [7:0] expected read
    localparam int NVEC = 28;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'h00, 8'h00}, {1'b0, 3'd2, 8'h11, 8'h00},
        {1'b0, 3'd3, 8'h21, 8'h00}, {1'b0, 3'd4, 8'h31, 8'h00},
        {1'b0, 3'd0, 8'h40, 8'h00}, {1'b0, 3'd2, 8'h12, 8'h00},
        {1'b0, 3'd3, 8'h22, 8'h00}, {1'b0, 3'd4, 8'h32, 8'h00},
        {1'b0, 3'd0, 8'h85, 8'h00}, {1'b0, 3'd2, 8'h13, 8'h00},
        {1'b0, 3'd3, 8'h23, 8'h00}, {1'b0, 3'd4, 8'h33, 8'h00},
        {1'b1, 3'd2, 8'h00, 8'h13}, {1'b1, 3'd0, 8'h00, 8'h85},
        {1'b0, 3'd0, 8'h41, 8'h00}, {1'b1, 3'd2, 8'h00, 8'h12},
        {1'b1, 3'd3, 8'h00, 8'h22}, {1'b1, 3'd4, 8'h00, 8'h32},
        {1'b0, 3'd0, 8'h02, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h31},
        {1'b0, 3'd1, 8'h5A, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h5A},
        {1'b0, 3'd5, 8'hC3, 8'h00}, {1'b1, 3'd5, 8'h00, 8'hC3},
        {1'b0, 3'd7, 8'h0F, 8'h00}, {1'b1, 3'd7, 8'h00, 8'h0F},
        {1'b0, 3'd6, 8'hFF, 8'h00}, {1'b1, 3'd6, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; addr = a; host_din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = dout[7:0];
        check("R8 upper pad", {20'd0, dout[11:8]}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 cfg in reset", {24'd0, cfg_o}, 32'd0);
        check("R1 gain in reset", {8'd0, gain_rgb}, 32'd0);
        rst_n = 1'b1;
        host_read(3'd0, rd_val);
        check("R1 cfg read after reset", {24'd0, rd_val}, 32'd0);
        host_read(3'd3, rd_val);
        check("R1 odd read after reset", {24'd0, rd_val}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) begin
                host_read(VEC[i][18:16], rd_val);
                check($sformatf("R3/R6/R7 vector %0d", i), {24'd0, rd_val}, {24'd0, VEC[i][7:0]});
            end else begin
                host_write(VEC[i][18:16], VEC[i][15:8], 1'b0);
            end
        end

        check("R4 gain lanes", {8'd0, gain_rgb}, 32'h00131211);
        check("R4 odd lanes", {8'd0, odd_off_rgb}, 32'h00232221);
        check("R4 even lanes", {8'd0, even_off_rgb}, 32'h00333231);
        check("R7 bayer after reserved write", {24'd0, bayer_o}, 32'h0F);
        check("R7 cfg2 after reserved write", {24'd0, cfg2_o}, 32'h5A);
        check("R3 input offset port", {24'd0, in_off_o}, 32'hC3);

        host_write(3'd0, 8'hFF, 1'b1);
        @(negedge clk);
        check("R2 cs high ignored", {24'd0, cfg_o}, 32'h02);

        @(negedge clk);
        cs_n = 1'b0; addr = 3'd1; host_din = 8'h77; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 no commit while strobe low", {24'd0, cfg2_o}, 32'h5A);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        check("R2 commit on strobe rise", {24'd0, cfg2_o}, 32'h77);

        host_write(3'd0, 8'hC0, 1'b0);
        host_write(3'd2, 8'h99, 1'b0);
        host_write(3'd4, 8'h98, 1'b0);
        @(negedge clk);
        check("R5 no-color gain write dropped", {8'd0, gain_rgb}, 32'h00131211);
        check("R5 no-color even write dropped", {8'd0, even_off_rgb}, 32'h00333231);
        host_read(3'd2, rd_val);
        check("R5 no-color read zero", {24'd0, rd_val}, 32'd0);
        host_write(3'd0, 8'h80, 1'b0);
        host_read(3'd3, rd_val);
        check("R6 blue odd readback", {24'd0, rd_val}, 32'h23);

        @(negedge clk);
        sample_in = 12'hABC; oe_n = 1'b0;
        #1;
        check("R8 sample passthrough", {20'd0, dout}, 32'hABC);
        check("R8 pins driven", {31'd0, dout_oe}, 32'd1);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 3'd1;
        #1;
        check("R8 readback overrides sample", {20'd0, dout}, 32'h077);
        oe_n = 1'b1;
        #1;
        check("R8 pins off data", {20'd0, dout}, 32'd0);
        check("R8 pins off enable", {31'd0, dout_oe}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b1; oe_n = 1'b0;

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears cfg2", {24'd0, cfg2_o}, 32'd0);
        check("R1 reset clears even", {8'd0, even_off_rgb}, 32'd0);
        rst_n = 1'b1;
        host_read(3'd7, rd_val);
        check("R1 bayer read zero", {24'd0, rd_val}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule